// File: doc/BRIEF.md
# Load-Load Ordering Violation Checker

This block watches loads that are in flight in a small circular load queue. It flags the case where an older load reads memory after a younger load to the same bytes has already obtained its data. When an older load is queried and such a younger load exists, the load pipeline must restart execution from fetch.

The load pipeline sends a query in its first stage. The query carries:
- the load's queue slot and its wrap bit,
- its physical address and 16-bit byte mask,
- whether its data is already valid,
- whether the access is non-cacheable.

The block accepts queries with a ready/valid handshake. Ready drops while the data cache is releasing a line, and the load must then be retried by its issuer. Exactly one cycle after a query is accepted, the block returns a response with a single restart-from-fetch flag.

An accepted query is written into its own queue slot, so that later, older loads can be checked against it. That write can be cancelled by a revoke pulse in the following cycle. Queue slots are allocated and released by index from outside the block.

Top module: `ll_order_check`

## Requirements
- R1: A response (`resp_valid` high) appears in exactly the cycle after a query is accepted (`q_valid` and `q_ready` both high at a clock edge), and in no other cycle.
- R2: `q_ready` is low while `release_busy` is high. A query presented then gets no response and is not written into its slot.
- R3: `resp_fetch` is high when all of these hold for some allocated slot:
  - the slot holds a written query with data valid,
  - that slot is younger than the querying load,
  - its address bits [31:4] equal the query's,
  - its byte mask shares at least one set bit with the query's mask.
- R4: `resp_fetch` stays low when every written slot fails one of the tests in R3: it is older than or equal to the query, it lies in another 16-byte line, its mask is disjoint from the query's, or its data flag is clear.
- R5: Age is decided from {wrap, index}. With equal wrap bits, the larger index is younger. With different wrap bits, the smaller index is younger.
- R6: A query with `q_nc` high never produces `resp_fetch` high.
- R7: An accepted query is written into slot `q_idx` at the end of the next cycle. The write records the line, the mask and the data flag, and is skipped if `q_revoke` is high in that next cycle.
- R8: A query accepted in the cycle right after another query already sees that earlier query, unless it is revoked in that same cycle.
- R9: An allocation sets a slot's wrap bit and clears its written state. A free empties the slot. A write into a slot that is not allocated is dropped. Priority on one slot is allocation, then free, then write.
- R10: After reset `resp_valid` and `resp_fetch` are low and no slot is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate slot `alloc_idx` |
| alloc_idx | input | 3 | Slot to allocate |
| alloc_wrap | input | 1 | Wrap bit given to the allocated slot |
| free_valid | input | 1 | Release slot `free_idx` |
| free_idx | input | 3 | Slot to release |
| release_busy | input | 1 | Data cache is releasing a line; blocks queries |
| q_valid | input | 1 | Query present |
| q_ready | output | 1 | Query can be accepted |
| q_idx | input | 3 | Querying load's slot |
| q_wrap | input | 1 | Querying load's wrap bit |
| q_paddr | input | 32 | Physical address |
| q_mask | input | 16 | Byte mask within the 16-byte line |
| q_data_ok | input | 1 | Load's data is valid |
| q_nc | input | 1 | Non-cacheable access |
| q_revoke | input | 1 | Cancel the write of last cycle's accepted query |
| resp_valid | output | 1 | Response for last cycle's accepted query |
| resp_fetch | output | 1 | Violation: restart from fetch |

## Verification
The bench checks the following hazards directly:
- A query issued in the cycle right after a younger one. A design that waits for the write to land before checking would miss this violation.
- A revoked write. A design that ignores the revoke would flag a later, older load falsely.
- A wrap-bit flip that makes the lower index the younger one. A design that compares indices alone would get the order backwards.
- Non-cacheable queries and queries during a line release. These must never flag and must never respond, respectively.

Freed and reallocated slots must not carry stale written state. A long random run, with slots reallocated under flipped wrap bits, compares every response against a reference model of the queue.

// File: rtl/ll_pkg.sv
package ll_pkg;

  // True when the load tagged {a_w,a_i} comes after {b_w,b_i} in program order.
  function automatic logic is_younger(logic a_w, int unsigned a_i,
                                      logic b_w, int unsigned b_i);
    if (a_w == b_w) return a_i > b_i;
    else            return a_i < b_i;
  endfunction

endpackage

// File: rtl/ll_slot.sv
module ll_slot
  import ll_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int LINE_W = 28,
  parameter int MASK_W = 16,
  parameter int MY_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              alloc_wrap_i,
  input  logic              free_i,
  input  logic              wr_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic [MASK_W-1:0] wr_mask_i,
  input  logic              wr_dok_i,
  input  logic              chk_i,
  input  logic [IDX_W-1:0]  chk_idx_i,
  input  logic              chk_wrap_i,
  input  logic [LINE_W-1:0] chk_line_i,
  input  logic [MASK_W-1:0] chk_mask_i,
  output logic              valid_o,
  output logic              hit_o
);

  logic              valid_q, valid_d;
  logic              wrap_q,  wrap_d;
  logic              rec_q,   rec_d;
  logic              dok_q,   dok_d;
  logic [LINE_W-1:0] line_q,  line_d;
  logic [MASK_W-1:0] mask_q,  mask_d;

  always_comb begin
    valid_d = valid_q;
    wrap_d  = wrap_q;
    rec_d   = rec_q;
    dok_d   = dok_q;
    line_d  = line_q;
    mask_d  = mask_q;
    if (alloc_i) begin
      valid_d = 1'b1;
      wrap_d  = alloc_wrap_i;
      rec_d   = 1'b0;
      dok_d   = 1'b0;
    end else if (free_i) begin
      valid_d = 1'b0;
      rec_d   = 1'b0;
      dok_d   = 1'b0;
    end else if (wr_i && valid_q) begin
      rec_d  = 1'b1;
      dok_d  = wr_dok_i;
      line_d = wr_line_i;
      mask_d = wr_mask_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      wrap_q  <= 1'b0;
      rec_q   <= 1'b0;
      dok_q   <= 1'b0;
      line_q  <= '0;
      mask_q  <= '0;
    end else begin
      valid_q <= valid_d;
      wrap_q  <= wrap_d;
      rec_q   <= rec_d;
      dok_q   <= dok_d;
      line_q  <= line_d;
      mask_q  <= mask_d;
    end
  end

  assign valid_o = valid_q;
  assign hit_o   = chk_i && valid_q && rec_q && dok_q
                && is_younger(wrap_q, MY_IDX, chk_wrap_i, 32'(chk_idx_i))
                && (line_q == chk_line_i)
                && (|(mask_q & chk_mask_i));

  AST_FREE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (free_i && !alloc_i) |=> !valid_o); // R9
  AST_ALLOC_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> !hit_o); // R9

endmodule

// File: rtl/ll_stage1.sv
module ll_stage1 #(
  parameter int IDX_W  = 3,
  parameter int LINE_W = 28,
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wrap_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              dok_i,
  input  logic              revoke_i,
  output logic              wr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              wrap_o,
  output logic [LINE_W-1:0] line_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              dok_o
);

  logic              vld_q, vld_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              wrap_q, wrap_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              dok_q, dok_d;

  always_comb begin
    vld_d  = acc_i;
    idx_d  = idx_q;
    wrap_d = wrap_q;
    line_d = line_q;
    mask_d = mask_q;
    dok_d  = dok_q;
    if (acc_i) begin
      idx_d  = idx_i;
      wrap_d = wrap_i;
      line_d = line_i;
      mask_d = mask_i;
      dok_d  = dok_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      idx_q  <= '0;
      wrap_q <= 1'b0;
      line_q <= '0;
      mask_q <= '0;
      dok_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      idx_q  <= idx_d;
      wrap_q <= wrap_d;
      line_q <= line_d;
      mask_q <= mask_d;
      dok_q  <= dok_d;
    end
  end

  assign wr_o   = vld_q && !revoke_i;
  assign idx_o  = idx_q;
  assign wrap_o = wrap_q;
  assign line_o = line_q;
  assign mask_o = mask_q;
  assign dok_o  = dok_q;

  AST_WRITE_ONLY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_i |=> !wr_o); // R7

endmodule

// File: rtl/ll_order_check.sv
module ll_order_check
  import ll_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int PA_W   = 32,
  parameter int MASK_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid,
  input  logic [$clog2(SLOTS)-1:0] alloc_idx,
  input  logic                     alloc_wrap,
  input  logic                     free_valid,
  input  logic [$clog2(SLOTS)-1:0] free_idx,
  input  logic                     release_busy,
  input  logic                     q_valid,
  output logic                     q_ready,
  input  logic [$clog2(SLOTS)-1:0] q_idx,
  input  logic                     q_wrap,
  input  logic [PA_W-1:0]          q_paddr,
  input  logic [MASK_W-1:0]        q_mask,
  input  logic                     q_data_ok,
  input  logic                     q_nc,
  input  logic                     q_revoke,
  output logic                     resp_valid,
  output logic                     resp_fetch
);

  localparam int IDX_W  = $clog2(SLOTS);
  localparam int OFF_W  = $clog2(MASK_W);
  localparam int LINE_W = PA_W - OFF_W;

  logic              acc, chk;
  logic [LINE_W-1:0] q_line;
  logic              s1_wr, s1_wrap, s1_dok;
  logic [IDX_W-1:0]  s1_idx;
  logic [LINE_W-1:0] s1_line;
  logic [MASK_W-1:0] s1_mask;
  logic [SLOTS-1:0]  slot_valid, slot_hit;
  logic              byp_hit;
  logic              rv_q, rv_d, rf_q, rf_d;

  assign q_ready = !release_busy;
  assign acc     = q_valid && q_ready;
  assign chk     = acc && !q_nc;
  assign q_line  = q_paddr[PA_W-1:OFF_W];

  ll_stage1 #(.IDX_W(IDX_W), .LINE_W(LINE_W), .MASK_W(MASK_W)) u_s1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_i    (acc),
    .idx_i    (q_idx),
    .wrap_i   (q_wrap),
    .line_i   (q_line),
    .mask_i   (q_mask),
    .dok_i    (q_data_ok),
    .revoke_i (q_revoke),
    .wr_o     (s1_wr),
    .idx_o    (s1_idx),
    .wrap_o   (s1_wrap),
    .line_o   (s1_line),
    .mask_o   (s1_mask),
    .dok_o    (s1_dok)
  );

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    ll_slot #(.IDX_W(IDX_W), .LINE_W(LINE_W), .MASK_W(MASK_W), .MY_IDX(k)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (alloc_valid && (alloc_idx == IDX_W'(k))),
      .alloc_wrap_i (alloc_wrap),
      .free_i       (free_valid && (free_idx == IDX_W'(k))),
      .wr_i         (s1_wr && (s1_idx == IDX_W'(k))),
      .wr_line_i    (s1_line),
      .wr_mask_i    (s1_mask),
      .wr_dok_i     (s1_dok),
      .chk_i        (chk),
      .chk_idx_i    (q_idx),
      .chk_wrap_i   (q_wrap),
      .chk_line_i   (q_line),
      .chk_mask_i   (q_mask),
      .valid_o      (slot_valid[k]),
      .hit_o        (slot_hit[k])
    );
  end

  // Forward the query still in stage 1 so a back-to-back older load sees it.
  assign byp_hit = chk && s1_wr && slot_valid[s1_idx] && s1_dok
                && is_younger(s1_wrap, 32'(s1_idx), q_wrap, 32'(q_idx))
                && (s1_line == q_line)
                && (|(s1_mask & q_mask));

  always_comb begin
    rv_d = acc;
    rf_d = chk && ((|slot_hit) || byp_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rf_q <= 1'b0;
    end else begin
      rv_q <= rv_d;
      rf_q <= rf_d;
    end
  end

  assign resp_valid = rv_q;
  assign resp_fetch = rf_q;

  AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !release_busy) |=> resp_valid); // R1
  AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> !resp_valid); // R1
  AST_RELEASE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    release_busy |=> !resp_valid); // R2
  AST_NC_NEVER_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_ready && q_nc) |=> !resp_fetch); // R6
  AST_FETCH_NEEDS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fetch |-> resp_valid); // R3

endmodule

// File: tb/sim_ll_order_check.sv
`timescale 1ns/1ps
module sim_ll_order_check;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 0, alloc_wrap = 0, free_valid = 0;
  logic [2:0]  alloc_idx = 0, free_idx = 0, q_idx = 0;
  logic        release_busy = 0, q_valid = 0, q_wrap = 0;
  logic [31:0] q_paddr = 0;
  logic [15:0] q_mask = 0;
  logic        q_data_ok = 0, q_nc = 0, q_revoke = 0;
  logic        q_ready, resp_valid, resp_fetch;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  ll_order_check u0 (.*);

  // reference model
  logic        m_val [N];
  logic        m_wrap[N];
  logic        m_rec [N];
  logic        m_dok [N];
  logic [27:0] m_line[N];
  logic [15:0] m_mask[N];
  logic        p_vld, p_wrap, p_dok;
  logic [2:0]  p_idx;
  logic [27:0] p_line;
  logic [15:0] p_mask;
  logic        e_rv, e_rf;

  function automatic logic younger(logic aw, int ai, logic bw, int bi);
    return (aw == bw) ? (ai > bi) : (ai < bi);
  endfunction

  function automatic logic predict();
    logic f = 0;
    if (!(q_valid && !release_busy) || q_nc) return 0;
    for (int k = 0; k < N; k++)
      if (m_val[k] && m_rec[k] && m_dok[k] && younger(m_wrap[k], k, q_wrap, int'(q_idx))
          && m_line[k] == q_paddr[31:4] && (m_mask[k] & q_mask) != 0) f = 1;
    if (p_vld && !q_revoke && m_val[p_idx] && p_dok
        && younger(p_wrap, int'(p_idx), q_wrap, int'(q_idx))
        && p_line == q_paddr[31:4] && (p_mask & q_mask) != 0) f = 1;
    return f;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    logic acc;
    acc  = q_valid && !release_busy;
    e_rv = acc;
    e_rf = predict();
    @(posedge clk); #1;
    // model update: write from stage 1, then free/alloc priority per slot
    for (int k = 0; k < N; k++) begin
      if (alloc_valid && alloc_idx == k) begin
        m_val[k] = 1; m_wrap[k] = alloc_wrap; m_rec[k] = 0; m_dok[k] = 0;
      end else if (free_valid && free_idx == k) begin
        m_val[k] = 0; m_rec[k] = 0; m_dok[k] = 0;
      end else if (p_vld && !q_revoke && p_idx == k && m_val[k]) begin
        m_rec[k] = 1; m_dok[k] = p_dok; m_line[k] = p_line; m_mask[k] = p_mask;
      end
    end
    p_vld = acc;
    if (acc) begin
      p_idx = q_idx; p_wrap = q_wrap; p_dok = q_data_ok;
      p_line = q_paddr[31:4]; p_mask = q_mask;
    end
    chk(resp_valid, e_rv, {tag, " resp_valid (R1)"});
    chk(resp_fetch, e_rf, {tag, " resp_fetch"});
  endtask

  task automatic idle();
    alloc_valid = 0; free_valid = 0; q_valid = 0; q_revoke = 0;
    release_busy = 0; q_nc = 0;
  endtask

  task automatic query(input int idx, input logic w, input logic [31:0] a,
                       input logic [15:0] m, input logic dok);
    idle();
    q_valid = 1; q_idx = 3'(idx); q_wrap = w; q_paddr = a; q_mask = m; q_data_ok = dok;
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin
      m_val[k] = 0; m_wrap[k] = 0; m_rec[k] = 0; m_dok[k] = 0; m_line[k] = 0; m_mask[k] = 0;
    end
    p_vld = 0; p_idx = 0; p_wrap = 0; p_dok = 0; p_line = 0; p_mask = 0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk(resp_valid, 1'b0, "R10 reset resp_valid");
    chk(resp_fetch, 1'b0, "R10 reset resp_fetch");
    rst_n = 1;
    // R10: queries before any allocation never flag
    query(2, 0, 32'h100, 16'hFFFF, 1); cyc("R10 empty");
    query(1, 0, 32'h100, 16'hFFFF, 1); cyc("R10 empty");
    chk(resp_fetch, 1'b0, "R10 no slots allocated");
    for (int k = 0; k < N; k++) begin
      idle(); alloc_valid = 1; alloc_idx = 3'(k); alloc_wrap = 0; cyc("R9 alloc");
    end
    // R3 basic violation
    query(5, 0, 32'h1000_0008, 16'h00F0, 1); cyc("R3 young");
    idle(); cyc("R7 settle");
    query(2, 0, 32'h1000_0004, 16'h0030, 1); cyc("R3");
    chk(resp_fetch, 1'b1, "R3 younger overlap");
    // R4 cases
    query(2, 0, 32'h1000_0000, 16'h0F00, 1); cyc("R4");
    chk(resp_fetch, 1'b0, "R4 disjoint mask");
    query(2, 0, 32'h1000_0010, 16'h00F0, 1); cyc("R4");
    chk(resp_fetch, 1'b0, "R4 other line");
    query(7, 0, 32'h1000_0000, 16'h00F0, 0); cyc("R4");
    chk(resp_fetch, 1'b0, "R4 recorded slot is older");
    // R6
    query(2, 0, 32'h1000_0000, 16'h00F0, 1); q_nc = 1; cyc("R6");
    chk(resp_fetch, 1'b0, "R6 non-cacheable");
    // R7 revoke
    query(6, 0, 32'h2000_0000, 16'h00FF, 1); cyc("R7");
    idle(); q_revoke = 1; cyc("R7");
    query(1, 0, 32'h2000_0000, 16'h00FF, 1); cyc("R7");
    chk(resp_fetch, 1'b0, "R7 revoked write dropped");
    // R8 back-to-back
    query(4, 0, 32'h3000_0000, 16'h0001, 1); cyc("R8");
    query(3, 0, 32'h3000_0000, 16'h0001, 1); cyc("R8");
    chk(resp_fetch, 1'b1, "R8 forward from stage 1");
    // R2 release
    query(6, 0, 32'h4000_0000, 16'hFFFF, 1); release_busy = 1;
    #0.5; chk(q_ready, 1'b0, "R2 ready low");
    cyc("R2");
    chk(resp_valid, 1'b0, "R2 no response");
    query(0, 0, 32'h4000_0000, 16'hFFFF, 1); cyc("R2");
    chk(resp_fetch, 1'b0, "R2 refused query not written");
    // R5 wrap
    idle(); alloc_valid = 1; alloc_idx = 0; alloc_wrap = 1; cyc("R5");
    query(0, 1, 32'h5000_0000, 16'h0001, 1); cyc("R5");
    idle(); cyc("R5");
    query(7, 0, 32'h5000_0000, 16'h0001, 0); cyc("R5");
    chk(resp_fetch, 1'b1, "R5 lower index younger after wrap");
    // R9 free then realloc
    idle(); free_valid = 1; free_idx = 0; cyc("R9");
    query(7, 0, 32'h5000_0000, 16'h0001, 0); cyc("R9");
    chk(resp_fetch, 1'b0, "R9 freed slot ignored");
    idle(); alloc_valid = 1; alloc_idx = 0; alloc_wrap = 1; cyc("R9");
    query(6, 0, 32'h5000_0000, 16'h0001, 1); cyc("R9");
    chk(resp_fetch, 1'b0, "R9 alloc clears written state");
    // random phase, compared against the model (R3)
    for (int i = 0; i < 4000; i++) begin
      int qi;
      idle();
      qi = $urandom % N;
      q_valid      = ($urandom % 4) != 0;
      q_idx        = 3'(qi);
      q_wrap       = m_wrap[qi];
      q_paddr      = {27'h0, 1'(($urandom % 2)), 4'($urandom)};
      q_mask       = 16'($urandom & $urandom & $urandom);
      q_data_ok    = ($urandom % 3) != 0;
      q_nc         = ($urandom % 8) == 0;
      release_busy = ($urandom % 8) == 0;
      q_revoke     = ($urandom % 6) == 0;
      if (($urandom % 16) == 0) begin
        alloc_valid = 1; alloc_idx = 3'($urandom); alloc_wrap = ~m_wrap[alloc_idx];
      end
      if (($urandom % 32) == 0) begin
        free_valid = 1; free_idx = 3'($urandom);
      end
      cyc("R3 random");
    end
    idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule